// File: doc/BRIEF.md
# Merged-Comb CIC Decimator

This block lowers the sample rate of a signed data stream by a fixed integer ratio. It applies the classic cascaded integrator-comb lowpass response, (1 − z^-RATIO)^ORDER / (1 − z^-1)^ORDER, and uses no multipliers. The comb differential delay is fixed at one decimated sample. Input samples arrive with a valid strobe on a single clock. One full-precision result leaves with a one-cycle strobe for every RATIO accepted samples.

The design saves one comb stage. The first ORDER−1 integrators run at the input rate in the usual way. The final integrator also acts as the rate-change switch. On an ordinary accepted sample it adds the value produced by the stage before it. On the sample that closes a decimation group it hands its accumulated window to the comb section and reloads itself with the preceding stage's fresh value, without adding. Each value handed over is therefore a running sum of RATIO samples, which is the first differentiation. Only ORDER−1 combs follow, and they run at the decimated rate.

All internal registers and the output use the same width: IN_W + ORDER·ceil(log2(RATIO)) bits. Two's-complement wraparound inside the integrators has no effect on the result.

Top module: `cic_merged_decim`

## Requirements
- R1: With the accepted samples numbered x[0], x[1], ... from the end of reset, the k-th output (k = 0, 1, ...) is y[k] = Σ h[j]·x[(k+1)·RATIO − 2 − j]. Here h is the length-RATIO all-ones sequence convolved with itself ORDER times, and a sample with a negative index counts as zero.
- R2: out_data is a two's-complement value of IN_W + ORDER·ceil(log2(RATIO)) bits. A constant input at the most negative input code reaches the most negative output code, −2^(IN_W−1)·RATIO^ORDER, without error.
- R3: out_valid is high for exactly one cycle: the cycle that follows the clock edge accepting the RATIO-th sample of each group. Groups are counted from the end of reset, and at no other time is out_valid high.
- R4: A cycle with in_valid low is ignored: its in_data value has no effect on any later output, and no group count advances.
- R5: out_data holds its value in every cycle in which out_valid is low.
- R6: A synchronous reset drives out_valid low and out_data to zero. It clears all history, so the samples that follow produce exactly the outputs of R1, as if no earlier input had been seen.
- R7: Wraparound of the integrators during long runs of large input values does not change the outputs. A constant input c produces c·RATIO^ORDER once the response has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_data in this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new decimated result |
| out_data | output | IN_W + ORDER·ceil(log2(RATIO)) | Signed full-precision decimated result |

## Verification
The assertions assume that the build uses RATIO and ORDER of at least 2. They also assume that rst is held high from time zero until after the first clock edge. Under those assumptions the output strobe can never occur on two adjacent cycles. The assertions further take for granted that in_data may hold any value while in_valid is low. The bench relies on exactly that freedom: it drives random values during idle cycles, and it opens every scenario with a reset that lasts several cycles. Input codes range over the full signed span, including the most negative one, because R2 and R7 depend on those extremes.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

  // Bits needed to hold the full-precision result of the filter.
  function automatic int stage_width(input int in_w, input int order, input int ratio);
    return in_w + order * $clog2(ratio);
  endfunction

  // Bits needed for the group position counter.
  function automatic int group_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/cic_tick_gen.sv
`timescale 1ns/1ps
module cic_tick_gen
  import cic_pkg::*;
#(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic tick
);
  localparam int CW = group_bits(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] pos;

  assign tick = in_valid && (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (in_valid)
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/cic_integ_chain.sv
`timescale 1ns/1ps
module cic_integ_chain #(
  parameter int NS    = 2,
  parameter int IN_W  = 16,
  parameter int ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic [ACC_W-1:0] feed
);
  // Wrapping two's-complement add at accumulator width.
  function automatic logic [ACC_W-1:0] wrap_add(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  logic [ACC_W-1:0] x_ext;
  logic [ACC_W-1:0] acc [NS];
  logic [ACC_W-1:0] nxt [NS];

  assign x_ext = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};

  for (genvar g = 0; g < NS; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign nxt[g] = wrap_add(acc[g], x_ext);
    end else begin : g_rest
      assign nxt[g] = wrap_add(acc[g], nxt[g-1]);
    end

    always_ff @(posedge clk) begin
      if (rst)
        acc[g] <= '0;
      else if (in_valid)
        acc[g] <= nxt[g];
    end
  end

  // Value that the last plain integrator takes on this sample.
  assign feed = nxt[NS-1];
endmodule

// File: rtl/cic_merge_stage.sv
`timescale 1ns/1ps
module cic_merge_stage #(
  parameter int ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             tick,
  input  logic [ACC_W-1:0] feed,
  output logic [ACC_W-1:0] acc
);
  function automatic logic [ACC_W-1:0] wrap_add(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  // Ordinary samples accumulate; the group-closing sample restarts the
  // window from the preceding stage, so acc always spans RATIO terms
  // when it is handed to the combs.
  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (tick)
      acc <= feed;
    else if (in_valid)
      acc <= wrap_add(acc, feed);
  end
endmodule

// File: rtl/cic_comb_chain.sv
`timescale 1ns/1ps
module cic_comb_chain #(
  parameter int NC    = 2,
  parameter int ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  function automatic logic [ACC_W-1:0] wrap_sub(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a - b;
  endfunction

  logic [ACC_W-1:0] d   [NC+1];
  logic [ACC_W-1:0] dly [NC];

  assign d[0] = din;

  for (genvar g = 0; g < NC; g++) begin : g_comb
    assign d[g+1] = wrap_sub(d[g], dly[g]);

    always_ff @(posedge clk) begin
      if (rst)
        dly[g] <= '0;
      else if (tick)
        dly[g] <= d[g];
    end
  end

  assign dout = d[NC];
endmodule

// File: rtl/cic_merged_decim.sv
`timescale 1ns/1ps
module cic_merged_decim
  import cic_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int RATIO = 4,
  parameter int IN_W  = 16,
  localparam int ACC_W = stage_width(IN_W, ORDER, RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data
);
  localparam int N_PLAIN = ORDER - 1;
  localparam int N_COMB  = ORDER - 1;

  if (ORDER < 2 || RATIO < 2) begin : g_bad_cfg
    $error("cic_merged_decim needs ORDER >= 2 and RATIO >= 2");
  end

  logic             dec_tick;
  logic [ACC_W-1:0] tail_feed;
  logic [ACC_W-1:0] tail_acc;
  logic [ACC_W-1:0] comb_out;

  cic_tick_gen #(.RATIO(RATIO)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .tick     (dec_tick)
  );

  cic_integ_chain #(.NS(N_PLAIN), .IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .feed     (tail_feed)
  );

  cic_merge_stage #(.ACC_W(ACC_W)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .tick     (dec_tick),
    .feed     (tail_feed),
    .acc      (tail_acc)
  );

  cic_comb_chain #(.NC(N_COMB), .ACC_W(ACC_W)) u_comb (
    .clk  (clk),
    .rst  (rst),
    .tick (dec_tick),
    .din  (tail_acc),
    .dout (comb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= dec_tick;
      if (dec_tick)
        out_data <= comb_out;
    end
  end
endmodule

// File: rtl/cic_merged_decim_chk.sv
`timescale 1ns/1ps
module cic_merged_decim_chk #(
  parameter int RATIO = 4,
  parameter int ACC_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             dec_tick,
  input logic [ACC_W-1:0] tail_feed,
  input logic [ACC_W-1:0] tail_acc,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_data
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [CW-1:0] seen;
  logic          group_end;
  logic          strobe_due;

  assign group_end = in_valid && (seen == CW'(RATIO - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen       <= '0;
      strobe_due <= 1'b0;
    end else begin
      strobe_due <= group_end;
      if (in_valid)
        seen <= group_end ? '0 : seen + 1'b1;
    end
  end

  // R3: internal tick marks the RATIO-th accepted sample of a group
  p_tick_place_r3: assert property (@(posedge clk) disable iff (rst)
    dec_tick == group_end);

  // R3: output strobe follows the group-closing edge
  p_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid == strobe_due);

  // R3: strobe lasts a single cycle
  p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5: result holds when no group closes
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !dec_tick |=> $stable(out_data));

  // R1: last integrator restarts its window from the preceding stage
  p_reload_r1: assert property (@(posedge clk) disable iff (rst)
    dec_tick |=> (tail_acc == $past(tail_feed)));

  // R1: last integrator accumulates on ordinary samples
  p_accum_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_tick) |=> (tail_acc == ACC_W'($past(tail_acc) + $past(tail_feed))));

  // R4: idle cycles leave the last integrator untouched
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(tail_acc));

  // R6: reset clears the output side
  p_reset_r6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

bind cic_merged_decim cic_merged_decim_chk #(.RATIO(RATIO), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dec_tick  (dec_tick),
  .tail_feed (tail_feed),
  .tail_acc  (tail_acc),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_cic_merged_decim.sv
`timescale 1ns/1ps
module tb_cic_merged_decim;
  localparam int ORDER = 3;
  localparam int RATIO = 4;
  localparam int IN_W  = 16;
  localparam int OUT_W = IN_W + ORDER * $clog2(RATIO);
  localparam int HLEN  = ORDER * (RATIO - 1) + 1;
  localparam int HMAX  = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  int     checks = 0;
  int     bad = 0;
  longint h    [HLEN];
  longint hist [HMAX];
  int     nacc = 0;
  longint last_out = 0;

  always #2.5 clk = ~clk;

  cic_merged_decim #(.ORDER(ORDER), .RATIO(RATIO), .IN_W(IN_W)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Impulse response: all-ones boxcar of length RATIO, convolved ORDER times.
  task automatic build_h();
    longint tmp [HLEN];
    int     len = 1;
    for (int i = 0; i < HLEN; i++) h[i] = 0;
    h[0] = 1;
    for (int s = 0; s < ORDER; s++) begin
      for (int i = 0; i < HLEN; i++) tmp[i] = 0;
      for (int i = 0; i < len; i++)
        for (int j = 0; j < RATIO; j++)
          tmp[i+j] += h[i];
      len = len + RATIO - 1;
      for (int i = 0; i < HLEN; i++) h[i] = tmp[i];
    end
  endtask

  // Expected output for the group closed by accepted sample t (R1).
  function automatic longint model(input int t);
    longint s = 0;
    for (int j = 0; j < HLEN; j++) begin
      int idx = t - 1 - j;
      if (idx >= 0) s += h[j] * hist[idx];
    end
    return s;
  endfunction

  task automatic step(input bit v, input logic [IN_W-1:0] d, input string tag);
    bit     exp_strobe = 1'b0;
    longint act;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v) begin
      hist[nacc] = longint'($signed(d));
      if (nacc % RATIO == RATIO - 1) exp_strobe = 1'b1;
      nacc++;
    end
    @(posedge clk);
    #1;
    act = longint'($signed(out_data));
    chk(out_valid == exp_strobe, "R3 strobe", longint'(out_valid), longint'(exp_strobe));
    if (exp_strobe) begin
      longint e = model(nacc - 1);
      chk(act == e, tag, act, e);
      last_out = e;
    end else begin
      chk(act == last_out, "R5 hold", act, last_out);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R6 reset strobe", longint'(out_valid), 0);
    chk(out_data == '0, "R6 reset data", longint'($signed(out_data)), 0);
    @(negedge clk);
    rst = 1'b0;
    nacc = 0;
    last_out = 0;
  endtask

  task automatic t_impulse();
    do_reset();
    step(1'b1, 16'sd1000, "R1 impulse");
    for (int i = 0; i < 23; i++) step(1'b1, '0, "R1 impulse");
  endtask

  task automatic t_full_negative();
    do_reset();
    for (int i = 0; i < 48; i++) step(1'b1, 16'h8000, "R2 full scale");
    chk(last_out == -(longint'(1) << (OUT_W - 1)), "R2 most negative",
        last_out, -(longint'(1) << (OUT_W - 1)));
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 1200; i++) step(1'b1, 16'sd32767, "R7 wrap");
    chk(last_out == 64'sd32767 * RATIO * RATIO * RATIO, "R7 dc gain",
        last_out, 64'sd32767 * RATIO * RATIO * RATIO);
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 240; i++) begin
      bit v = ($urandom() % 2) == 0;
      step(v, IN_W'($urandom()), "R4 gaps");
    end
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 300; i++) step(1'b1, IN_W'($urandom()), "R1 random");
  endtask

  task automatic t_alternate();
    do_reset();
    for (int i = 0; i < 64; i++)
      step(1'b1, (i % 2 == 0) ? 16'sd20000 : -16'sd20000, "R1 alternating");
  endtask

  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 16'sd12345, "R1 before reset");
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1, IN_W'(i * 911 - 7000), "R6 after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired after %0d checks", checks);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    build_h();
    t_impulse();
    t_full_negative();
    t_wrap();
    t_gaps();
    t_random();
    t_alternate();
    t_midreset();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule